// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is a purely combinational integer datapath for a 32-bit processor core. It receives an operation code and a first operand. It also receives a second operand that an external shifter has already prepared, together with the carry that shifter produced. The incoming N, Z, C and V condition flags complete its inputs. From these it forms a result word and the flag values that the core should hold after the instruction.

Five arithmetic forms are supported: add, add with carry, subtract, subtract with carry, and reverse subtract. Five bitwise forms are also supported: AND, OR, exclusive OR, AND-NOT and OR-NOT. The carry flag feeds into the carrying forms, so software can build sums and differences of 64, 96 or more bits one word per operation. A branch-target mode clears bit 0 of the written value. A separate output evaluates the "unsigned higher" predicate on the incoming flags.

Top module: `alu_flag_unit`

## Requirements
- R1: Code 0 (add) gives Rn+Op2, and code 1 (add-carry) gives Rn+Op2+C_in. When flags update, C is the carry out of bit 31 and V is signed overflow.
- R2: Code 2 (subtract) gives Rn-Op2, and code 3 (subtract-carry) gives Rn+NOT(Op2)+C_in. C is set exactly when no borrow occurs, and V is signed overflow.
- R3: Code 4 (reverse subtract) gives Op2-Rn, with C and V set as for subtract.
- R4: Codes 5 to 9 give Rn AND Op2, Rn OR Op2, Rn XOR Op2, Rn AND NOT Op2 and Rn OR NOT Op2, in that order.
- R5: For the bitwise codes with flag update, C takes shift_carry_i and V keeps v_i.
- R6: With flag update on a defined code, N equals result bit 31, and Z is set exactly when the computed value is zero.
- R7: With set_flags_i low, n_o, z_o, c_o and v_o equal n_i, z_i, c_i and v_i.
- R8: With pc_dest_i high, result bit 0 is 0 and the upper bits are unchanged. The flags are computed on the value before bit 0 is cleared.
- R9: hi_o is 1 exactly when c_i is 1 and z_i is 0.
- R10: Codes 10 to 15 give a result of 0 and leave all four flags unchanged.
- R11: Chaining add then add-carry gives the correct 64-bit sum and final carry. Chaining subtract then two subtract-carry steps gives the correct 96-bit difference, with a final C equal to "no borrow".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see R1-R4, R10) |
| rn_i | input | 32 | First operand |
| op2_i | input | 32 | Pre-shifted second operand |
| set_flags_i | input | 1 | Update flags from this operation |
| pc_dest_i | input | 1 | Destination is the program counter; clear bit 0 |
| shift_carry_i | input | 1 | Carry out of the external shifter |
| n_i | input | 1 | Current negative flag |
| z_i | input | 1 | Current zero flag |
| c_i | input | 1 | Current carry flag |
| v_i | input | 1 | Current overflow flag |
| result_o | output | 32 | Result word |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| v_o | output | 1 | Next overflow flag |
| hi_o | output | 1 | Unsigned-higher predicate on incoming flags |

## Verification
The hardest cases to reach are those where the incoming carry decides the outcome across a word boundary. Examples are a middle word of a 96-bit difference that borrows only because the lower word borrowed, or a sum that is all ones plus carry-in and wraps to zero. Random operands almost never land there. The bench therefore feeds the flags produced by one operation back as the inputs of the next, to build multiword chains. It also adds directed operand pairs that are equal, differ by one, or are all ones, so that these carry and borrow boundaries are hit.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_RSB = 4'd4,
    OP_AND = 4'd5,
    OP_ORR = 4'd6,
    OP_EOR = 4'd7,
    OP_BIC = 4'd8,
    OP_ORN = 4'd9
  } alu_op_e;

  function automatic logic is_arith(alu_op_e op);
    return op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB};
  endfunction

  function automatic logic is_logic(alu_op_e op);
    return op inside {OP_AND, OP_ORR, OP_EOR, OP_BIC, OP_ORN};
  endfunction
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W:0] wide;

  always_comb begin
    wide   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_o  = wide[W-1:0];
    cout_o = wide[W];
    // signed overflow: same-sign inputs, differing sign out
    ovf_o  = (a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1]);
  end

  // an unsigned wrap leaves a sum below the first addend
  always_comb begin
    if (!cin_i && cout_o) p_wrap_r1: assert (sum_o < a_i);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  alu_pkg::alu_op_e op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic [W-1:0]     res_o
);
  import alu_pkg::*;

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_ORR:  res_o = a_i | b_i;
      OP_EOR:  res_o = a_i ^ b_i;
      OP_BIC:  res_o = a_i & ~b_i;
      OP_ORN:  res_o = a_i | ~b_i;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == OP_BIC) p_bic_r4: assert ((res_o & b_i) == '0);
    if (op_i == OP_ORN) p_orn_r4: assert ((res_o | b_i) == '1);
    if (op_i == OP_EOR) p_eor_r4: assert ((res_o ^ b_i) == a_i);
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int W = 32
) (
  input  logic         set_i,
  input  logic         arith_i,
  input  logic         logic_i,
  input  logic [W-1:0] val_i,
  input  logic         add_c_i,
  input  logic         add_v_i,
  input  logic         sh_c_i,
  input  logic [3:0]   nzcv_i,
  output logic [3:0]   nzcv_o
);
  logic upd;

  always_comb begin
    upd    = set_i && (arith_i || logic_i);
    nzcv_o = nzcv_i;
    if (upd) begin
      nzcv_o[3] = val_i[W-1];
      nzcv_o[2] = (val_i == '0);
      nzcv_o[1] = arith_i ? add_c_i : sh_c_i;
      nzcv_o[0] = arith_i ? add_v_i : nzcv_i[0];
    end
  end

  always_comb begin
    if (!set_i) p_hold_flags_r7: assert (nzcv_o == nzcv_i);
    if (!arith_i && !logic_i) p_undef_hold_r10: assert (nzcv_o == nzcv_i);
    if (upd && nzcv_o[2]) p_zero_pos_r6: assert (!nzcv_o[3]);
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] rn_i,
  input  logic [W-1:0] op2_i,
  input  logic         set_flags_i,
  input  logic         pc_dest_i,
  input  logic         shift_carry_i,
  input  logic         n_i,
  input  logic         z_i,
  input  logic         c_i,
  input  logic         v_i,
  output logic [W-1:0] result_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o,
  output logic         hi_o
);
  import alu_pkg::*;

  alu_op_e    op;
  logic       arith, lgc;
  logic [W-1:0] add_a, add_b, sum, lres, raw;
  logic       add_cin, add_c, add_v;
  logic [3:0] nzcv_next;

  assign op    = alu_op_e'(op_i);
  assign arith = is_arith(op);
  assign lgc   = is_logic(op);

  always_comb begin
    add_a   = rn_i;
    add_b   = op2_i;
    add_cin = 1'b0;
    unique case (op)
      OP_ADC: add_cin = c_i;
      OP_SUB: begin add_b = ~op2_i; add_cin = 1'b1; end
      OP_SBC: begin add_b = ~op2_i; add_cin = c_i; end
      OP_RSB: begin add_a = op2_i; add_b = ~rn_i; add_cin = 1'b1; end
      default: ;
    endcase
  end

  alu_adder #(.W(W)) u_add (
    .a_i(add_a), .b_i(add_b), .cin_i(add_cin),
    .sum_o(sum), .cout_o(add_c), .ovf_o(add_v)
  );

  alu_logic #(.W(W)) u_log (
    .op_i(op), .a_i(rn_i), .b_i(op2_i), .res_o(lres)
  );

  assign raw      = arith ? sum : (lgc ? lres : '0);
  assign result_o = pc_dest_i ? {raw[W-1:1], 1'b0} : raw;

  alu_flag_gen #(.W(W)) u_flg (
    .set_i(set_flags_i), .arith_i(arith), .logic_i(lgc), .val_i(raw),
    .add_c_i(add_c), .add_v_i(add_v), .sh_c_i(shift_carry_i),
    .nzcv_i({n_i, z_i, c_i, v_i}), .nzcv_o(nzcv_next)
  );

  assign {n_o, z_o, c_o, v_o} = nzcv_next;
  assign hi_o = c_i & ~z_i;

  always_comb begin
    if (pc_dest_i) p_pc_even_r8: assert (result_o[0] == 1'b0);
    if (hi_o) p_hi_r9: assert (c_i && !z_i);
    if (op == OP_SUB && set_flags_i) p_no_borrow_r2: assert (c_o == (rn_i >= op2_i));
    if (!arith && !lgc) p_undef_zero_r10: assert (result_o == '0);
  end
endmodule

// File: tb/sim_alu_flag_unit.sv
module sim_alu_flag_unit;
  localparam int W = 32;

  logic clk = 1'b0;
  always #4ns clk = ~clk;

  logic [3:0]   op;
  logic [W-1:0] rn, op2, res;
  logic sf, pcd, shc, n, z, c, v, no, zo, co, vo, hi;

  int vectors = 0;
  int errs = 0;
  bit done = 1'b0;

  alu_flag_unit #(.W(W)) u0 (
    .op_i(op), .rn_i(rn), .op2_i(op2), .set_flags_i(sf), .pc_dest_i(pcd),
    .shift_carry_i(shc), .n_i(n), .z_i(z), .c_i(c), .v_i(v),
    .result_o(res), .n_o(no), .z_o(zo), .c_o(co), .v_o(vo), .hi_o(hi)
  );

  // reference: {result, n, z, c, v}
  function automatic logic [W+3:0] model(logic [3:0] o, logic [W-1:0] a, logic [W-1:0] b,
                                         logic s, logic p, logic sh, logic [3:0] f);
    logic [W-1:0] r;
    logic [3:0] nf;
    longint u, sg, x, y, bo;
    logic ar, lg, cc, vv;
    r = '0; cc = 1'b0; vv = 1'b0; ar = 1'b0; lg = 1'b0;
    case (o)
      4'd0, 4'd1: begin
        ar = 1'b1;
        bo = (o == 4'd1) ? longint'(f[1]) : 0;
        u  = longint'(a) + longint'(b) + bo;
        sg = longint'($signed(a)) + longint'($signed(b)) + bo;
        r = u[W-1:0]; cc = (u >= 64'h1_0000_0000);
        vv = (sg > 64'sh7FFF_FFFF) || (sg < -64'sh8000_0000);
      end
      4'd2, 4'd3, 4'd4: begin
        ar = 1'b1;
        x = (o == 4'd4) ? longint'(b) : longint'(a);
        y = (o == 4'd4) ? longint'(a) : longint'(b);
        bo = (o == 4'd3) ? longint'(!f[1]) : 0;
        u = x - y - bo;
        r = u[W-1:0]; cc = (u >= 0);
        sg = (o == 4'd4) ? longint'($signed(b)) - longint'($signed(a))
                         : longint'($signed(a)) - longint'($signed(b)) - bo;
        vv = (sg > 64'sh7FFF_FFFF) || (sg < -64'sh8000_0000);
      end
      4'd5: begin lg = 1'b1; r = a & b; end
      4'd6: begin lg = 1'b1; r = a | b; end
      4'd7: begin lg = 1'b1; r = a ^ b; end
      4'd8: begin lg = 1'b1; r = a & ~b; end
      4'd9: begin lg = 1'b1; r = a | ~b; end
      default: r = '0;
    endcase
    nf = f;
    if (s && (ar || lg)) begin
      nf[3] = r[W-1];
      nf[2] = (r == 0);
      nf[1] = ar ? cc : sh;
      nf[0] = ar ? vv : f[0];
    end
    if (p) r[0] = 1'b0;
    return {r, nf};
  endfunction

  task automatic drive(logic [3:0] o, logic [W-1:0] a, logic [W-1:0] b,
                       logic s, logic p, logic sh, logic [3:0] f);
    @(negedge clk);
    op = o; rn = a; op2 = b; sf = s; pcd = p; shc = sh; {n, z, c, v} = f;
    #1ns;
  endtask

  task automatic check(string tag);
    logic [W+3:0] exp;
    exp = model(op, rn, op2, sf, pcd, shc, {n, z, c, v});
    vectors++;
    if ({res, no, zo, co, vo} !== exp) begin
      errs++;
      $display("FAIL %s op=%0d rn=%h op2=%h: got res=%h nzcv=%b exp res=%h nzcv=%b",
               tag, op, rn, op2, res, {no, zo, co, vo}, exp[W+3:4], exp[3:0]);
    end
    vectors++;
    if (hi !== (c & ~z)) begin
      errs++;
      $display("FAIL R9 hi: got %b exp %b", hi, c & ~z);
    end
  endtask

  task automatic vec(string tag, logic [3:0] o, logic [W-1:0] a, logic [W-1:0] b,
                     logic s, logic p, logic sh, logic [3:0] f);
    drive(o, a, b, s, p, sh, f);
    check(tag);
  endtask

  task automatic expect_val(string tag, logic [127:0] got, logic [127:0] exp);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    logic [63:0] a64, b64, s64;
    logic [95:0] a96, b96, d96;
    logic [W-1:0] lo, md;
    logic cr;
    void'($urandom(32'h5eed_1234));
    op = '0; rn = '0; op2 = '0; sf = 0; pcd = 0; shc = 0; {n, z, c, v} = '0;
    #1ns;
    check("R6 initial zero add");

    // directed corners
    vec("R1 wrap to zero", 4'd0, 32'hFFFF_FFFF, 32'h1, 1, 0, 0, 4'b0000);
    vec("R1 signed ovf", 4'd0, 32'h7FFF_FFFF, 32'h1, 1, 0, 0, 4'b0000);
    vec("R1 adc all ones", 4'd1, 32'hFFFF_FFFF, 32'h0, 1, 0, 0, 4'b0010);
    vec("R2 equal sub", 4'd2, 32'h1234, 32'h1234, 1, 0, 0, 4'b0000);
    vec("R2 borrow", 4'd2, 32'h0, 32'h1, 1, 0, 0, 4'b0010);
    vec("R2 sbc borrow-in", 4'd3, 32'h5, 32'h5, 1, 0, 0, 4'b0000);
    vec("R2 sub signed ovf", 4'd2, 32'h8000_0000, 32'h1, 1, 0, 0, 4'b0000);
    vec("R3 rsb", 4'd4, 32'h10, 32'd1280, 1, 0, 0, 4'b0000);
    vec("R3 rsb borrow", 4'd4, 32'h10, 32'h1, 1, 0, 0, 4'b0000);
    vec("R4 bic", 4'd8, 32'hF0F0_FFFF, 32'h0000_FF00, 1, 0, 1, 4'b0001);
    vec("R4 orn", 4'd9, 32'h0, 32'hFFFF_FFFE, 1, 0, 0, 4'b1001);
    vec("R5 and keeps V", 4'd5, 32'h0, 32'hFFFF, 1, 0, 1, 4'b0001);
    vec("R7 hold flags", 4'd2, 32'h0, 32'h1, 0, 0, 0, 4'b0110);
    vec("R8 pc dest", 4'd0, 32'h1000_0000, 32'h3, 0, 1, 0, 4'b0000);
    vec("R8 pc dest flags", 4'd0, 32'h0, 32'h1, 1, 1, 0, 4'b0000);
    vec("R9 hi true", 4'd6, 32'h1, 32'h2, 0, 0, 0, 4'b0010);
    vec("R10 undef", 4'd12, 32'hDEAD_BEEF, 32'h1, 1, 0, 1, 4'b1010);
    vec("R10 undef max", 4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0, 4'b0101);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      vec("R1-R10 random", 4'($urandom_range(0, 15)), $urandom, $urandom,
          1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom));
    end

    // 64-bit add chains
    for (int i = 0; i < 200; i++) begin
      a64 = {$urandom, $urandom}; b64 = {$urandom, $urandom};
      if (i == 0) begin a64 = 64'h0000_0000_FFFF_FFFF; b64 = 64'h1; end
      drive(4'd0, a64[31:0], b64[31:0], 1, 0, 0, 4'b0000);
      check("R1 chain lo");
      lo = res; cr = co;
      drive(4'd1, a64[63:32], b64[63:32], 1, 0, 0, {2'b00, cr, 1'b0});
      check("R1 chain hi");
      s64 = a64 + b64;
      expect_val("R11 add64 sum", {64'h0, res, lo}, {64'h0, s64});
      expect_val("R11 add64 carry", {127'h0, co}, {127'h0, ({1'b0, a64} + {1'b0, b64}) >> 64});
    end

    // 96-bit subtract chains
    for (int i = 0; i < 200; i++) begin
      a96 = {$urandom, $urandom, $urandom}; b96 = {$urandom, $urandom, $urandom};
      if (i == 0) begin a96 = 96'h1_0000_0000_0000_0000; b96 = 96'h1; end
      if (i == 1) begin a96 = 96'h5; b96 = 96'h5; end
      drive(4'd2, a96[31:0], b96[31:0], 1, 0, 0, 4'b0000);
      check("R2 chain lo");
      lo = res; cr = co;
      drive(4'd3, a96[63:32], b96[63:32], 1, 0, 0, {2'b00, cr, 1'b0});
      check("R2 chain mid");
      md = res; cr = co;
      drive(4'd3, a96[95:64], b96[95:64], 1, 0, 0, {2'b00, cr, 1'b0});
      check("R2 chain hi");
      d96 = a96 - b96;
      expect_val("R11 sub96 diff", {32'h0, res, md, lo}, {32'h0, d96});
      expect_val("R11 sub96 no-borrow", {127'h0, co}, {127'h0, a96 >= b96});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule